// File: doc/BRIEF.md
# Frequency Loss-of-Lock Detector

This block decides whether a recovered line clock is running at the same frequency as the local reference clock. The reference domain sets a measurement gate of a fixed number of reference cycles, and the block counts recovered-clock edges during that gate. The count crosses between the two clock domains as a Gray code. At the end of each gate the count is compared against a tolerance band centred on the nominal value. The band width comes from a parts-per-million limit.

A single gate result never changes the lock state. The loss-of-lock flag is declared only after a run of consecutive out-of-band gates. It is released only after a longer run of consecutive in-band gates. A gate result of the opposite kind restarts the run.

The block drives three outputs:
- A level flag.
- A one-cycle interrupt pulse when the flag rises.
- A one-cycle event when the flag falls. Downstream logic can use this event, for example to re-centre a transmit FIFO.

A rate-select input chooses between the gate lengths for the two nominal line rates, 155.52 MHz and 139.264 MHz, so that both gates last the same time.

Top module: `freq_lol_detector`

## Requirements
- R1: During and directly after reset, `lol` is 1 and both `lol_irq` and `lol_clear` are 0.
- R2: A gate is in band when the number of recovered edges counted in it lies within G ± T, where G is the selected gate length and T = floor(G × PPM / 10^6). Otherwise the gate is out of band.
- R3: While `lol` is 0, it rises after SET_GATES consecutive out-of-band gates.
- R4: While `lol` is 1, it falls after CLR_GATES consecutive in-band gates.
- R5: A gate result of the opposite kind restarts the run. Bursts that are shorter than the run length therefore leave `lol` unchanged however often they repeat.
- R6: `lol_irq` is high for exactly one reference cycle each time `lol` rises, and at no other time.
- R7: `lol_clear` is high for exactly one reference cycle each time `lol` falls, and at no other time.
- R8: `rate_sel` = 1 selects the gate length GATE_HI, and `rate_sel` = 0 selects GATE_LO. The time needed to declare loss of lock scales with the selected gate length.
- R9: While `en` is 0, the following hold:
  - Measurement stops and `lol` holds its value.
  - Neither pulse output fires.
  - The run counters are cleared.
  - The first gate after `en` rises, or after reset, is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference clock; all outputs are in this domain |
| rec_clk | input | 1 | Recovered clock under test |
| rst_n | input | 1 | Synchronous active-low reset, in the reference domain |
| en | input | 1 | Measurement enable |
| rate_sel | input | 1 | 1 selects GATE_HI, 0 selects GATE_LO |
| lol | output | 1 | Loss-of-lock level flag |
| lol_irq | output | 1 | One-cycle pulse when `lol` rises |
| lol_clear | output | 1 | One-cycle pulse when `lol` falls |

## Verification
The hardest case to reach from the ports is the restart of a partly filled run. The bench cannot see the run counters, and a frequency step rarely lines up with a gate boundary, so one gate may be only partly bad. The bench therefore repeats bursts of off-frequency clock lasting two gate times, separated by nominal stretches. A burst this short gives at most three bad gates, one short of the declare threshold. The bench then checks that the flag never moves and that no interrupt appears, and runs the mirror-image test while the flag is high. The rate select is checked by timing: with the longer gate, the flag must still be low at a moment when the shorter gate would already have declared loss of lock.

// File: rtl/lol_pkg.sv
// Package: shared types for the frequency loss-of-lock detector.
// Assumes nothing beyond IEEE 1800-2017.
package lol_pkg;

    // Outcome of one measurement gate.
    typedef enum logic [1:0] {
        GATE_NONE = 2'd0,
        GATE_IN   = 2'd1,
        GATE_OUT  = 2'd2
    } gate_res_e;

    localparam longint PPM_SCALE = 1000000;

endpackage

// File: rtl/lol_edge_counter.sv
// Module: counts recovered-clock edges and publishes the count as Gray code.
// Assumes rst_n comes from the reference domain; it is re-timed here.
module lol_edge_counter #(
    parameter int CW = 16
) (
    input  logic          rclk,
    input  logic          rst_n,
    output logic [CW-1:0] gray_o
);

    logic [1:0]    rst_q;
    logic          rrst_n;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    assign rrst_n = rst_q[1];
    assign bin_nx = bin_q + CW'(1);

    // Re-time the reset into the recovered domain.
    always_ff @(posedge rclk) begin
        rst_q <= {rst_q[0], rst_n};
    end

    // Free-running binary edge count with registered Gray image.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // R2: the Gray image moves by at most one bit per edge, so the crossing is safe.
    assert_gray_step_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/lol_gray_sync.sv
// Module: two-flop synchronizer for the Gray count, then Gray-to-binary.
// Assumes the Gray input changes at most one bit per source edge.
module lol_gray_sync #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);

    logic [CW-1:0] s1_q;
    logic [CW-1:0] s2_q;

    // Two-stage capture into the reference domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_i;
            s2_q <= s1_q;
        end
    end

    // Gray-to-binary conversion of the synchronized value.
    always_comb begin
        bin_o[CW-1] = s2_q[CW-1];
        for (int i = CW - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ s2_q[i];
        end
    end

endmodule

// File: rtl/lol_gate_meter.sv
// Module: times a gate of reference cycles and grades the recovered edge
// count taken over it against a ppm band.
// Assumes rec_bin is a wrapping count in the reference domain.
// Discards the first gate after reset or enable.
module lol_gate_meter
    import lol_pkg::*;
#(
    parameter int CW      = 16,
    parameter int GATE_HI = 31104,
    parameter int GATE_LO = 27853,
    parameter int PPM     = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rate_sel,
    input  logic [CW-1:0] rec_bin,
    output gate_res_e     res_o
);

    localparam int GATE_MAX = (GATE_HI > GATE_LO) ? GATE_HI : GATE_LO;
    localparam int GW       = $clog2(GATE_MAX + 1);
    localparam longint TOL_HI = longint'(GATE_HI) * PPM / PPM_SCALE;
    localparam longint TOL_LO = longint'(GATE_LO) * PPM / PPM_SCALE;
    localparam logic [CW-1:0] MIN_HI = CW'(longint'(GATE_HI) - TOL_HI);
    localparam logic [CW-1:0] MAX_HI = CW'(longint'(GATE_HI) + TOL_HI);
    localparam logic [CW-1:0] MIN_LO = CW'(longint'(GATE_LO) - TOL_LO);
    localparam logic [CW-1:0] MAX_LO = CW'(longint'(GATE_LO) + TOL_LO);

    logic [GW-1:0] gcnt_q;
    logic [GW-1:0] glen;
    logic [CW-1:0] prev_q;
    logic [CW-1:0] delta;
    logic          armed_q;
    logic          gate_end;
    logic          in_band;

    assign glen     = rate_sel ? GW'(GATE_HI) : GW'(GATE_LO);
    assign gate_end = (gcnt_q >= glen - GW'(1));
    assign delta    = rec_bin - prev_q;
    assign in_band  = rate_sel ? (delta >= MIN_HI && delta <= MAX_HI)
                               : (delta >= MIN_LO && delta <= MAX_LO);

    // Gate timer, snapshot of the count and grading of each gate.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            gcnt_q  <= '0;
            prev_q  <= '0;
            armed_q <= 1'b0;
            res_o   <= GATE_NONE;
        end else begin
            res_o <= GATE_NONE;
            if (gate_end) begin
                gcnt_q  <= '0;
                prev_q  <= rec_bin;
                armed_q <= 1'b1;
                if (armed_q) res_o <= in_band ? GATE_IN : GATE_OUT;
            end else begin
                gcnt_q <= gcnt_q + GW'(1);
            end
        end
    end

    // R8: a graded gate is never followed by another graded gate on the next cycle.
    assert_gate_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o != GATE_NONE) |=> (res_o == GATE_NONE));

    // R9: no grade appears while measurement is disabled.
    assert_no_grade_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (res_o == GATE_NONE));

endmodule

// File: rtl/lol_hysteresis.sv
// Module: persistence counters that set and clear the loss-of-lock flag,
// with one-cycle pulses on each change.
// Assumes one grade per gate from the gate meter.
module lol_hysteresis
    import lol_pkg::*;
#(
    parameter int SET_GATES = 3,
    parameter int CLR_GATES = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  gate_res_e res_i,
    output logic      flag_o,
    output logic      rise_o,
    output logic      fall_o
);

    localparam int RUN_MAX = (SET_GATES > CLR_GATES) ? SET_GATES : CLR_GATES;
    localparam int RW      = $clog2(RUN_MAX + 1);

    logic [RW-1:0] run_q;

    // Count consecutive opposite-sense gates and flip the flag at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b1;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            run_q  <= '0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (!en) begin
                run_q <= '0;
            end else if (!flag_o) begin
                if (res_i == GATE_OUT) begin
                    if (run_q == RW'(SET_GATES - 1)) begin
                        flag_o <= 1'b1;
                        rise_o <= 1'b1;
                        run_q  <= '0;
                    end else begin
                        run_q <= run_q + RW'(1);
                    end
                end else if (res_i == GATE_IN) begin
                    run_q <= '0;
                end
            end else begin
                if (res_i == GATE_IN) begin
                    if (run_q == RW'(CLR_GATES - 1)) begin
                        flag_o <= 1'b0;
                        fall_o <= 1'b1;
                        run_q  <= '0;
                    end else begin
                        run_q <= run_q + RW'(1);
                    end
                end else if (res_i == GATE_OUT) begin
                    run_q <= '0;
                end
            end
        end
    end

    // R6: the interrupt accompanies every rise of the flag.
    assert_irq_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> rise_o);

    // R6: the interrupt lasts one cycle.
    assert_irq_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    // R7: the clear event accompanies every fall and only with the flag low.
    assert_clear_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> (fall_o && !flag_o));

    // R9: disabled means flag held and no pulses.
    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(flag_o) && !rise_o && !fall_o));

    // R5: the run counter never passes its longest limit.
    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RW'(RUN_MAX));

endmodule

// File: rtl/freq_lol_detector.sv
// Module: top of the frequency loss-of-lock detector.
// Chain: edge counter (recovered domain), Gray synchronizer, gate meter,
// hysteresis.
// Assumes both clocks run; reset is synchronous to ref_clk.
module freq_lol_detector #(
    parameter int GATE_HI   = 31104,
    parameter int GATE_LO   = 27853,
    parameter int PPM       = 100,
    parameter int SET_GATES = 3,
    parameter int CLR_GATES = 3
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    input  logic en,
    input  logic rate_sel,
    output logic lol,
    output logic lol_irq,
    output logic lol_clear
);

    localparam int GATE_MAX = (GATE_HI > GATE_LO) ? GATE_HI : GATE_LO;
    localparam int CW       = $clog2(GATE_MAX + 1) + 2;

    logic [CW-1:0]      rec_gray;
    logic [CW-1:0]      rec_bin;
    lol_pkg::gate_res_e gate_res;

    lol_edge_counter #(.CW(CW)) u_edges (
        .rclk   (rec_clk),
        .rst_n  (rst_n),
        .gray_o (rec_gray)
    );

    lol_gray_sync #(.CW(CW)) u_sync (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .gray_i (rec_gray),
        .bin_o  (rec_bin)
    );

    lol_gate_meter #(
        .CW      (CW),
        .GATE_HI (GATE_HI),
        .GATE_LO (GATE_LO),
        .PPM     (PPM)
    ) u_meter (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .en       (en),
        .rate_sel (rate_sel),
        .rec_bin  (rec_bin),
        .res_o    (gate_res)
    );

    lol_hysteresis #(
        .SET_GATES (SET_GATES),
        .CLR_GATES (CLR_GATES)
    ) u_hyst (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .en     (en),
        .res_i  (gate_res),
        .flag_o (lol),
        .rise_o (lol_irq),
        .fall_o (lol_clear)
    );

    // R1: no pulse output fires while reset is held.
    assert_quiet_reset_R1: assert property (@(posedge ref_clk)
        !rst_n |=> (lol && !lol_irq && !lol_clear));

endmodule

// File: tb/test_freq_lol_detector.sv
`timescale 1ns/1ps
// Bench: drives the reference and a recovered clock whose frequency offset is
// set in percent. Compares lock state and pulse counts with expectations
// worked out from the gate length, tolerance and run lengths.
module test_freq_lol_detector;

    localparam real CLK_PERIOD = 10.0;
    localparam int  G_HI   = 64;    // tolerance floor(64*0.05)  = 3
    localparam int  G_LO   = 160;   // tolerance floor(160*0.05) = 8
    localparam int  PPM_T  = 50000;
    localparam int  SET_T  = 4;
    localparam int  CLR_T  = 5;
    localparam int  WD_CYCLES = 150000;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic rate_sel = 1'b1;
    logic lol, lol_irq, lol_clear;

    real rec_half = CLK_PERIOD / 2.0;
    int  checks = 0;
    int  errors = 0;
    int  irq_rise = 0, irq_hi = 0, clr_rise = 0, clr_hi = 0;
    logic irq_d = 1'b0, clr_d = 1'b0;
    bit  finished = 1'b0;

    freq_lol_detector #(
        .GATE_HI   (G_HI),
        .GATE_LO   (G_LO),
        .PPM       (PPM_T),
        .SET_GATES (SET_T),
        .CLR_GATES (CLR_T)
    ) i_freq_lol_detector (
        .ref_clk   (ref_clk),
        .rec_clk   (rec_clk),
        .rst_n     (rst_n),
        .en        (en),
        .rate_sel  (rate_sel),
        .lol       (lol),
        .lol_irq   (lol_irq),
        .lol_clear (lol_clear)
    );

    always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;
    always #(rec_half) rec_clk = ~rec_clk;

    // Pulse monitor: counts rises and high cycles of both pulse outputs.
    always @(posedge ref_clk) begin
        if (rst_n) begin
            if (lol_irq) irq_hi++;
            if (lol_irq && !irq_d) irq_rise++;
            if (lol_clear) clr_hi++;
            if (lol_clear && !clr_d) clr_rise++;
        end
        irq_d = lol_irq;
        clr_d = lol_clear;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Offset of the recovered clock in percent of the reference frequency.
    task automatic set_off(input real pct);
        rec_half = (CLK_PERIOD / 2.0) / (1.0 + pct / 100.0);
    endtask

    // Expected grade for the offsets used: in band for both rates when |pct| <= 2.
    function automatic int exp_flag(input real pct);
        return (pct <= 2.0 && pct >= -2.0) ? 0 : 1;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic gates(input int n);
        cycles(n * (rate_sel ? G_HI : G_LO));
    endtask

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        real offs [9] = '{0.0, 1.5, -1.5, 10.0, -10.0, 15.0, -15.0, 0.0, 1.5};
        int  base_irq;
        int  exp_lol;
        cycles(5);
        // R1: reset state.
        check("R1 lol in reset", int'(lol), 1);
        check("R1 irq in reset", int'(lol_irq), 0);
        rst_n = 1'b1;
        en    = 1'b1;
        cycles(2);
        check("R1 lol after reset", int'(lol), 1);
        check("R1 clear after reset", int'(lol_clear), 0);

        // R4/R7: nominal clock locks after discard + CLR_T in-band gates.
        gates(CLR_T - 1);
        check("R4 still unlocked before run ends", int'(lol), 1);
        gates(4);
        check("R4 locked", int'(lol), 0);
        check("R7 one clear event", clr_rise, 1);
        check("R7 clear width", clr_hi, clr_rise);

        // R3/R6: +12 % is out of band; below SET_T gates no declare, then declare.
        set_off(12.0);
        gates(2);
        check("R3 no early declare", int'(lol), 0);
        gates(SET_T + 1);
        check("R3 declared", int'(lol), 1);
        check("R6 one irq", irq_rise, 1);
        check("R6 irq width", irq_hi, irq_rise);

        // R2: +1.5 % lies inside the band; lock returns.
        set_off(1.5);
        gates(CLR_T + 3);
        check("R2 in-band offset locks", int'(lol), 0);

        // R5: repeated bad bursts of two gate times never declare.
        base_irq = irq_rise;
        for (int k = 0; k < 4; k++) begin
            set_off(12.0);
            gates(2);
            set_off(0.0);
            gates(2);
        end
        check("R5 bursts leave lock", int'(lol), 0);
        check("R5 bursts give no irq", irq_rise, base_irq);

        // R5 mirror: with lol high, short good bursts never clear.
        set_off(-12.0);
        gates(SET_T + 3);
        check("R3 declared on negative offset", int'(lol), 1);
        for (int k = 0; k < 4; k++) begin
            set_off(0.0);
            gates(2);
            set_off(-12.0);
            gates(2);
        end
        check("R5 good bursts keep flag", int'(lol), 1);

        // Relock at the high rate for the next tests.
        set_off(0.0);
        gates(CLR_T + 3);
        check("R4 relock", int'(lol), 0);

        // R9: disabled with a bad clock -> flag held, no irq.
        base_irq = irq_rise;
        en = 1'b0;
        set_off(12.0);
        gates(20);
        check("R9 flag held while disabled", int'(lol), 0);
        check("R9 no irq while disabled", irq_rise, base_irq);

        // R8: low-rate gate is 160 cycles; declare needs (1+SET_T)*160 cycles.
        rate_sel = 1'b0;
        cycles(4);
        en = 1'b1;
        cycles(6 * G_HI);
        check("R8 long gate not yet declared", int'(lol), 0);
        cycles(8 * G_LO - 6 * G_HI);
        check("R8 long gate declared", int'(lol), 1);

        // Random mix of rates and offsets with a fixed seed.
        void'($urandom(32'd1234));
        for (int n = 0; n < 24; n++) begin
            real o;
            en = 1'b0;
            rate_sel = $urandom_range(0, 1);
            o = offs[$urandom_range(0, 8)];
            set_off(o);
            cycles(4);
            en = 1'b1;
            gates(1 + ((SET_T > CLR_T) ? SET_T : CLR_T) + 3);
            exp_lol = exp_flag(o);
            check($sformatf("R2 random offset %0.1f rate %0d", o, rate_sel), int'(lol), exp_lol);
        end
        check("R6 irq widths overall", irq_hi, irq_rise);
        check("R7 clear widths overall", clr_hi, clr_rise);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule